// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Stage

This block is the front of a processor pipeline whose instructions are one or two 16-bit words long. It keeps a 21-bit byte program counter, presents it to a byte-addressed program memory that returns 16 bits per access, and hands the next stage one completed instruction at a time with a one-cycle valid strobe. Two-word instructions are held back until both words are in, so the consumer never sees half an instruction.

The stage recognises two long forms: a memory-to-memory copy and an absolute jump. For a jump it rebuilds the target from fields in both words and redirects the program counter, so the following fetch comes from the target. When the word that should complete a long instruction does not carry the continuation prefix, the stage drops the pair, issues a no-operation and flags the sequence as illegal. A stall input freezes the counter and any half-assembled instruction.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stage clears its state: `fetch_addr` is 0x000000 and `insn_valid` and `insn_illegal` are 0. The first fetch after reset comes from address 0.
- R2: `fetch_data[7:0]` is the byte at the even address `fetch_addr`, `fetch_data[15:8]` the byte at the next address. A word whose high byte is not 0xEF and whose top nibble is not 0xC (a word with top nibble 0xF standing alone included) is a single-word instruction: one cycle after the unstalled edge that fetches it, `insn_valid` is 1, `insn_first` holds it, `insn_second` is 0 and `insn_long` is 0, and `fetch_addr` has advanced by 2.
- R3: A first word with top nibble 0xC is a copy; with a following word whose top nibble is 0xF, `insn_valid` pulses once, only after the second word, with `insn_first`/`insn_second` holding both words and `insn_long` 1; `fetch_addr` advances by 2 per word.
- R4: A first word with high byte 0xEF followed by a word with top nibble 0xF is a jump: it is reported as a two-word instruction and the next fetch address is {second[11:0], first[7:0], 0}.
- R5: If the word after a copy or jump first word lacks top nibble 0xF, the pair is issued as a no-operation: `insn_valid` and `insn_illegal` are 1, `insn_first`, `insn_second` and `insn_long` are 0, no jump is taken, the second word is not decoded as a new instruction, and `fetch_addr` still advances by 2.
- R6: At an edge where `stall` is 1, `fetch_addr` and any partly assembled instruction are held, and `insn_valid` is 0 in the following cycle.
- R7: The counter wraps modulo 2^21: advancing from 0x1FFFFE fetches address 0x000000 next.
- R8: `fetch_addr` bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freeze the stage for this cycle |
| fetch_data | input | 16 | Word read at `fetch_addr`, same cycle |
| fetch_addr | output | 21 | Byte address of the word being fetched |
| insn_valid | output | 1 | One-cycle strobe: an instruction is complete |
| insn_first | output | 16 | First word of the issued instruction |
| insn_second | output | 16 | Second word, 0 for single-word instructions |
| insn_long | output | 1 | Issued instruction has two words |
| insn_illegal | output | 1 | Broken two-word sequence issued as no-operation |

## Verification
The critical overlap is a stall landing in the very cycle where the second word of a jump or copy would complete the instruction, so that holding the partial instruction and loading the target contend for the same edge. A repeating stall pattern with two co-prime periods runs over a program dense in long forms, so stalls hit first words, second words and broken pairs alike. The scoreboard then judges each issued instruction against the expected words and the fetch address that must follow it, while every stalled edge is checked for a held address and an absent strobe.

// File: rtl/fetch_pkg.sv
// Package: shared constants, kinds and the opcode classifier for the fetch stage.
// Assumes 16-bit instruction words with the opcode in the high byte.
package fetch_pkg;

    localparam int WORD_W  = 16;
    localparam int OPHI_W  = 8;
    localparam int NIB_W   = 4;

    localparam logic [OPHI_W-1:0] JUMP_HI  = 8'hEF;
    localparam logic [NIB_W-1:0]  COPY_NIB = 4'hC;
    localparam logic [NIB_W-1:0]  TAIL_NIB = 4'hF;

    typedef enum logic [1:0] {
        KIND_ONE  = 2'd0,
        KIND_COPY = 2'd1,
        KIND_JUMP = 2'd2
    } insn_kind_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Decide the instruction kind from the opcode byte of a first word.
    function automatic insn_kind_e kind_of(input logic [OPHI_W-1:0] op_hi);
        if (op_hi == JUMP_HI)
            return KIND_JUMP;
        else if (op_hi[OPHI_W-1 -: NIB_W] == COPY_NIB)
            return KIND_COPY;
        else
            return KIND_ONE;
    endfunction

endpackage

// File: rtl/fetch_classify.sv
// Module: fetch_classify
// Purely combinational length decoder. Looks only at the opcode byte of the
// word on the memory bus; the caller decides whether that word is a first word.
module fetch_classify
    import fetch_pkg::*;
(
    input  logic [OPHI_W-1:0] op_hi,
    output insn_kind_e        kind
);

    // Map the opcode byte onto one of the three instruction kinds.
    always_comb begin
        kind = kind_of(op_hi);
    end

endmodule

// File: rtl/fetch_pc.sv
// Module: fetch_pc
// Byte program counter. Steps by one word per unstalled cycle, takes a load
// address instead when asked, and wraps modulo 2**ADDR_W.
// Assumes the load request is already qualified with the stall.
module fetch_pc #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] pc_q;

    // Counter register: reset to zero, hold, jump or advance by one word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (hold)
            pc_q <= pc_q;
        else if (load)
            pc_q <= load_addr;
        else
            pc_q <= pc_q + STEP;
    end

    assign pc = pc_q;

    assert_pc_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0);

    assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> pc_q == $past(pc_q));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load) |=> pc_q == $past(pc_q) + STEP);

    assert_pc_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && load) |=> pc_q == $past(load_addr));

endmodule

// File: rtl/fetch_assembler.sv
// Module: fetch_assembler
// Two-phase instruction assembler. In the first phase it either issues a
// single-word instruction or parks a long first word; in the second phase it
// completes the pair, or issues a flagged no-operation if the continuation
// prefix is missing. Produces the jump request for the program counter.
// Assumes `word` is the memory data for the current fetch address.
module fetch_assembler
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [WORD_W-1:0] word,
    input  insn_kind_e        kind_in,
    output logic              jump_take,
    output logic [ADDR_W-1:0] jump_target,
    output logic              out_valid,
    output logic              out_long,
    output logic              out_illegal,
    output logic [WORD_W-1:0] out_first,
    output logic [WORD_W-1:0] out_second
);

    localparam int LO_W = OPHI_W;
    localparam int HI_W = ADDR_W - 1 - LO_W;

    phase_e            phase_q;
    logic [WORD_W-1:0] held_q;
    insn_kind_e        held_kind_q;
    logic              tail_ok;

    // Continuation prefix test on the word now on the bus.
    assign tail_ok = (word[WORD_W-1 -: NIB_W] == TAIL_NIB);

    // Rebuild the word-aligned jump target from both words.
    assign jump_target = {word[HI_W-1:0], held_q[LO_W-1:0], 1'b0};

    // Request a redirect only when a jump completes on an unstalled edge.
    assign jump_take = !stall && (phase_q == PH_SECOND)
                       && (held_kind_q == KIND_JUMP) && tail_ok;

    // Phase tracking and parking of a long first word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_FIRST;
            held_q      <= '0;
            held_kind_q <= KIND_ONE;
        end else if (!stall) begin
            if (phase_q == PH_FIRST) begin
                if (kind_in != KIND_ONE) begin
                    phase_q     <= PH_SECOND;
                    held_q      <= word;
                    held_kind_q <= kind_in;
                end
            end else begin
                phase_q <= PH_FIRST;
            end
        end
    end

    // Issue register: strobe and words of the completed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_long    <= 1'b0;
            out_illegal <= 1'b0;
            out_first   <= '0;
            out_second  <= '0;
        end else if (stall) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
        end else if (phase_q == PH_FIRST) begin
            out_valid   <= (kind_in == KIND_ONE);
            out_illegal <= 1'b0;
            if (kind_in == KIND_ONE) begin
                out_long   <= 1'b0;
                out_first  <= word;
                out_second <= '0;
            end
        end else begin
            out_valid <= 1'b1;
            if (tail_ok) begin
                out_long    <= 1'b1;
                out_illegal <= 1'b0;
                out_first   <= held_q;
                out_second  <= word;
            end else begin
                out_long    <= 1'b0;
                out_illegal <= 1'b1;
                out_first   <= '0;
                out_second  <= '0;
            end
        end
    end

    assert_no_issue_in_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);

    assert_partial_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && phase_q == PH_SECOND) |=> (phase_q == PH_SECOND && $stable(held_q)));

    assert_illegal_is_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_first == '0 && out_second == '0 && !out_long));

    assert_long_has_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_long) |-> out_second[WORD_W-1 -: NIB_W] == TAIL_NIB);

    assert_jump_only_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jump_take |=> (phase_q == PH_FIRST && out_valid && out_long));

endmodule

// File: rtl/fetch_unit.sv
// Module: fetch_unit (top)
// Variable-length fetch stage: program counter, length decoder and two-phase
// assembler. Assumes a program memory that returns the word at fetch_addr in
// the same cycle, low byte at the even address.
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [15:0]       fetch_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              insn_valid,
    output logic [15:0]       insn_first,
    output logic [15:0]       insn_second,
    output logic              insn_long,
    output logic              insn_illegal
);

    insn_kind_e        kind;
    logic              jump_take;
    logic [ADDR_W-1:0] jump_target;
    logic [ADDR_W-1:0] pc;

    fetch_classify u_classify (
        .op_hi (fetch_data[WORD_W-1 -: OPHI_W]),
        .kind  (kind)
    );

    fetch_assembler #(.ADDR_W(ADDR_W)) u_assembler (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .word        (fetch_data),
        .kind_in     (kind),
        .jump_take   (jump_take),
        .jump_target (jump_target),
        .out_valid   (insn_valid),
        .out_long    (insn_long),
        .out_illegal (insn_illegal),
        .out_first   (insn_first),
        .out_second  (insn_second)
    );

    fetch_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (stall),
        .load      (jump_take),
        .load_addr (jump_target),
        .pc        (pc)
    );

    assign fetch_addr = pc;

    assert_addr_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[0] == 1'b0);

endmodule

// File: tb/fetch_unit_tb_top.sv
// Scoreboard bench: program-building tasks place words in a modelled memory and
// queue the expected issued instructions; a negedge monitor compares them.
module fetch_unit_tb_top;

    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic [15:0]   mem_rdata = 16'h0000;
    logic [AW-1:0] fetch_addr;
    logic          insn_valid, insn_long, insn_illegal;
    logic [15:0]   insn_first, insn_second;

    always #5 clk = ~clk;

    fetch_unit #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .fetch_data   (mem_rdata),
        .fetch_addr   (fetch_addr),
        .insn_valid   (insn_valid),
        .insn_first   (insn_first),
        .insn_second  (insn_second),
        .insn_long    (insn_long),
        .insn_illegal (insn_illegal)
    );

    typedef struct {
        logic [15:0]   w0;
        logic [15:0]   w1;
        logic          lng;
        logic          ill;
        logic [AW-1:0] nxt;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    exp_t          e;
    logic [15:0]   mem [logic [AW-1:0]];
    logic [AW-1:0] bp = '0;
    logic [AW-1:0] addr_q = '0;
    logic          stall_q = 1'b0;
    int            checks = 0;
    int            errors = 0;
    int            cyc = 0;
    bit            done = 0;

    function automatic logic [15:0] rd(input logic [AW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] w0, input logic [15:0] w1, input logic lng,
                        input logic ill, input logic [AW-1:0] nxt, input string tag);
        exp_t x;
        x.w0 = w0; x.w1 = w1; x.lng = lng; x.ill = ill; x.nxt = nxt; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Single-word instruction at the build pointer.
    task automatic put1(input logic [15:0] w, input string tag);
        mem[bp] = w;
        push(w, 16'h0000, 1'b0, 1'b0, bp + AW'(2), tag);
        bp = bp + AW'(2);
    endtask

    // Well-formed copy pair.
    task automatic put2(input logic [15:0] w0, input logic [15:0] w1, input string tag);
        mem[bp] = w0;
        mem[bp + AW'(2)] = w1;
        push(w0, w1, 1'b1, 1'b0, bp + AW'(4), tag);
        bp = bp + AW'(4);
    endtask

    // Absolute jump: target bits 8..1 in the first word, 20..9 in the second.
    task automatic put_jump(input logic [AW-1:0] t, input string tag);
        logic [15:0] w0, w1;
        w0 = {8'hEF, t[8:1]};
        w1 = {4'hF, t[20:9]};
        mem[bp] = w0;
        mem[bp + AW'(2)] = w1;
        push(w0, w1, 1'b1, 1'b0, t, tag);
        bp = t;
    endtask

    // Long first word followed by a word without the continuation prefix.
    task automatic put_bad(input logic [15:0] w0, input logic [15:0] w1, input string tag);
        mem[bp] = w0;
        mem[bp + AW'(2)] = w1;
        push(16'h0000, 16'h0000, 1'b0, 1'b1, bp + AW'(4), tag);
        bp = bp + AW'(4);
    endtask

    // Memory model, stall driver and scoreboard monitor, all away from posedge.
    always @(negedge clk) begin
        mem_rdata <= rd(fetch_addr);
        if (rst_n && !done) begin
            cyc++;
            if (stall_q) begin
                check(!insn_valid, "R6", "valid after stalled edge", 32'(insn_valid), 32'd0);
                check(fetch_addr == addr_q, "R6", "address held in stall", 32'(fetch_addr), 32'(addr_q));
            end
            if (insn_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected instruction", 32'(insn_first), 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(insn_first == e.w0, e.tag, "first word", 32'(insn_first), 32'(e.w0));
                    check(insn_second == e.w1, e.tag, "second word", 32'(insn_second), 32'(e.w1));
                    check(insn_long == e.lng, e.tag, "long flag", 32'(insn_long), 32'(e.lng));
                    check(insn_illegal == e.ill, e.tag, "illegal flag", 32'(insn_illegal), 32'(e.ill));
                    check(fetch_addr == e.nxt, e.tag, "next fetch address", 32'(fetch_addr), 32'(e.nxt));
                    check(fetch_addr[0] == 1'b0, "R8", "address alignment", 32'(fetch_addr), 32'd0);
                    if (exp_q.size() == 0) done = 1;
                end
            end
            addr_q  = fetch_addr;
            stall   = !done && ((cyc % 5 == 2) || (cyc % 7 == 0));
            stall_q = stall;
        end
    end

    initial begin
        // Program: reset vector jumps into a mixed block, then far away, then wraps.
        bp = '0;
        put_jump(21'h000040, "R1");
        put1(16'h0E55, "R2");
        put1(16'h6E12, "R2");
        put2(16'hC123, 16'hF456, "R3");
        put1(16'hF00D, "R2");
        put1(16'hEE01, "R2");
        put_bad(16'hC00A, 16'h1234, "R5");
        put2(16'hCFFF, 16'hF000, "R3");
        put_bad(16'hEF33, 16'hC555, "R5");
        put1(16'h2412, "R2");
        put_jump(21'h012340, "R4");
        put1(16'h0F05, "R2");
        put2(16'hC0F0, 16'hF0F0, "R3");
        put_jump(21'h1FFFFC, "R4");
        put1(16'h0A0A, "R7");
        put1(16'h0001, "R7");
        put_jump(21'h000040, "R7");

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(fetch_addr == '0, "R1", "address in reset", 32'(fetch_addr), 32'd0);
        check(!insn_valid, "R1", "valid in reset", 32'(insn_valid), 32'd0);
        check(!insn_illegal, "R1", "illegal in reset", 32'(insn_illegal), 32'd0);
        rst_n = 1'b1;

        while (!done && cyc < 4000) @(negedge clk);
        if (!done)
            check(1'b0, "WD", "watchdog expired, pending items", 32'(exp_q.size()), 32'd0);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule